// File: doc/BRIEF.md
# Latched Serial Result Output Port

This block sits between a converter core and an external serial reader. The core hands over a 16-bit result with a one-cycle strobe. The block holds the result in a port register and shifts it out on a data line that it can release to high impedance. The reader drives an active-low chip select and a serial clock. Both are sampled by the fast system clock through two-stage synchronizers. The tri-state line is modelled as a data bit (`sdo`) and an output enable (`sdo_oe`). An active-low ready flag (`drdy_n`) tells the reader that a word is waiting.

A strobe opens a two-cycle notice window, during which the ready flag is forced high. At the end of that window the block tries to load the word. The load succeeds only if the port is empty or the reader is deselected; otherwise the word is dropped.

The read side is a four-state machine:
- **IDLE**: the line is released.
- **SELECTED**: the line is driven with the MSB, and the block waits for the arming rising edge of the serial clock.
- **SHIFT**: each falling edge presents the next bit.
- **DRAIN**: chip select was withdrawn during a read. The bit on the line is held until the next falling edge.

The transitions are:
- IDLE→SELECTED when the synchronized select is low and the port is full.
- SELECTED→IDLE when select is withdrawn.
- SELECTED→SHIFT on a rising edge.
- SHIFT→DRAIN when select is withdrawn.
- SHIFT→IDLE on the falling edge after the LSB. This edge also empties the port.
- DRAIN→IDLE on the next falling edge.

Top module: `serial_result_port`

## Requirements
- R1: After reset, `drdy_n` is 1, `sdo_oe` is 0 and `sdo` is 0, and the port is empty.
- R2: A strobe forces `drdy_n` to 1 in the two cycles after it. The load attempt happens on the second clock edge after the strobe. After that edge, `drdy_n` is 0 whenever the port holds a word.
- R3: A load attempted while the synchronized select is high is accepted even if an unread word is waiting. The new word replaces the old one.
- R4: A load attempted while the reader is selected and the port still holds a word not fully read is discarded. The read in progress continues with the old word.
- R5: When the synchronized select is low and the port is full, `sdo_oe` goes to 1 with the MSB (bit 15) on `sdo`.
- R6: A falling serial clock edge seen before the first rising edge after selection is ignored, and the MSB stays on the line.
- R7: After arming, each falling edge presents the next lower bit, so the word leaves MSB first.
- R8: The falling edge that follows the LSB (bit 0) sets `sdo_oe` to 0, marks the port empty and drives `drdy_n` to 1.
- R9: If select is withdrawn in the middle of a read, the current bit stays driven until the next falling edge. The line is then released, the port stays full and `drdy_n` stays 0.
- R10: Reselecting after an aborted read restarts the read from the MSB.
- R11: If a load attempt falls in the same cycle as the falling edge that completes a read, the attempt is accepted. A still-low select then presents the new word's MSB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also the converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| res_strobe | input | 1 | One-cycle strobe announcing a new result |
| res_word | input | 16 | Result word, captured with the strobe |
| cs_n | input | 1 | Reader chip select, active low, asynchronous |
| sclk | input | 1 | Reader serial clock, asynchronous |
| sdo | output | 1 | Serial data bit, valid while `sdo_oe` is 1 |
| sdo_oe | output | 1 | Output enable modelling the tri-state data line |
| drdy_n | output | 1 | Active-low data-ready flag |

## Verification
Two functions can fall in the same cycle: a load attempt and the falling edge that finishes a read and empties the port. To provoke this, the bench shifts a word down to its LSB. It then drives the serial clock low and pulses the strobe on the same clock. Both inputs reach the block two edges later in the same cycle: the clock through its synchronizer, the strobe through the notice window. The bench judges the result at the ports. `drdy_n` must be low, the line must be driven again with the new word's MSB, and the new word must then read out completely. A discarded word would instead leave `drdy_n` high with the line released.

// File: rtl/srp_pkg.sv
`timescale 1ns/1ps
package srp_pkg;
    typedef enum logic [1:0] {
        PS_IDLE     = 2'd0,
        PS_SELECTED = 2'd1,
        PS_SHIFT    = 2'd2,
        PS_DRAIN    = 2'd3
    } port_state_t;
endpackage

// File: rtl/srp_sync.sv
`timescale 1ns/1ps
module srp_sync #(
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= {STAGES{RST_VAL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/srp_load_ctrl.sv
`timescale 1ns/1ps
module srp_load_ctrl #(
    parameter int W      = 16,
    parameter int NOTICE = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] word_in,
    output logic         notice,
    output logic         attempt,
    output logic [W-1:0] word_held
);
    localparam int CW = $clog2(NOTICE + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            word_held <= '0;
        end else if (strobe) begin
            cnt       <= CW'(NOTICE);
            word_held <= word_in;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign notice  = (cnt != '0);
    assign attempt = (cnt == CW'(1)) && !strobe;

    // R2: a strobe always opens the notice window
    a_r2_notice_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> notice);
endmodule

// File: rtl/srp_shifter.sv
`timescale 1ns/1ps
module srp_shifter
    import srp_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_hi,
    input  logic         sclk_s,
    input  logic         attempt,
    input  logic [W-1:0] word_in,
    output logic         full,
    output logic         sdo,
    output logic         sdo_oe
);
    localparam int IW = $clog2(W);
    localparam logic [IW-1:0] MSB_IDX = IW'(W - 1);

    port_state_t   state, state_nx;
    logic [W-1:0]  shreg;
    logic [IW-1:0] idx;
    logic          bit_q;
    logic          sclk_prev;
    logic          rise, fall, done, accept;

    assign rise   = sclk_s && !sclk_prev;
    assign fall   = !sclk_s && sclk_prev;
    assign done   = (state == PS_SHIFT) && !cs_hi && fall && (idx == '0);
    assign accept = attempt && (!full || cs_hi || done);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            PS_IDLE:     if (full && !cs_hi) state_nx = PS_SELECTED;
            PS_SELECTED: if (cs_hi) state_nx = PS_IDLE;
                         else if (rise) state_nx = PS_SHIFT;
            PS_SHIFT:    if (cs_hi) state_nx = PS_DRAIN;
                         else if (done) state_nx = PS_IDLE;
            PS_DRAIN:    if (fall) state_nx = PS_IDLE;
            default:     state_nx = PS_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PS_IDLE;
        else        state <= state_nx;
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg     <= '0;
            full      <= 1'b0;
            idx       <= MSB_IDX;
            bit_q     <= 1'b0;
            sclk_prev <= 1'b1;
        end else begin
            sclk_prev <= sclk_s;
            if (accept) begin
                shreg <= word_in;
                full  <= 1'b1;
            end else if (done) begin
                full  <= 1'b0;
            end
            if (state == PS_IDLE) begin
                idx <= MSB_IDX;
                if (state_nx == PS_SELECTED) bit_q <= shreg[W-1];
            end else if (state == PS_SHIFT && !cs_hi && fall && idx != '0) begin
                idx   <= idx - 1'b1;
                bit_q <= shreg[idx - 1'b1];
            end
        end
    end

    // outputs
    always_comb begin
        sdo_oe = (state != PS_IDLE);
        sdo    = sdo_oe && bit_q;
    end

    // R5: the line is enabled with the MSB of the held word
    a_r5_select_shows_msb: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_oe) |-> (bit_q == shreg[W-1]) && full);
    // R6: a falling edge while not yet armed leaves the bit untouched
    a_r6_unarmed_fall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_SELECTED && fall && !cs_hi) |=> (sdo_oe && $stable(bit_q)));
    // R9: an aborted read holds its bit until a falling edge
    a_r9_drain_holds_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == PS_DRAIN && !fall) |=> (sdo_oe && $stable(bit_q)));
    // R4: a busy port keeps its word
    a_r4_busy_discards: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt && full && !cs_hi && !done) |=> $stable(shreg));
    // R8: completion releases the line
    a_r8_done_releases: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !sdo_oe);
    // R11: collision between completion and load keeps the new word
    a_r11_collision_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (attempt && done) |=> full);
endmodule

// File: rtl/serial_result_port.sv
`timescale 1ns/1ps
module serial_result_port #(
    parameter int W           = 16,
    parameter int NOTICE      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         res_strobe,
    input  logic [W-1:0] res_word,
    input  logic         cs_n,
    input  logic         sclk,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         drdy_n
);
    logic         cs_hi, sclk_s;
    logic         notice, attempt, full;
    logic [W-1:0] word_held;

    srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_hi));

    srp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));

    srp_load_ctrl #(.W(W), .NOTICE(NOTICE)) u_load (
        .clk(clk), .rst_n(rst_n), .strobe(res_strobe), .word_in(res_word),
        .notice(notice), .attempt(attempt), .word_held(word_held));

    srp_shifter #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_hi(cs_hi), .sclk_s(sclk_s),
        .attempt(attempt), .word_in(word_held), .full(full),
        .sdo(sdo), .sdo_oe(sdo_oe));

    assign drdy_n = notice || !full;

    // R2: the flag is high throughout the notice window
    a_r2_ready_high_in_notice: assert property (@(posedge clk) disable iff (!rst_n)
        notice |-> drdy_n);
endmodule

// File: tb/tb_serial_result_port.sv
`timescale 1ns/1ps
module tb_serial_result_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        res_strobe;
    logic [15:0] res_word;
    logic        cs_n, sclk;
    logic        sdo, sdo_oe, drdy_n;
    int          n_checks = 0;
    int          n_fail   = 0;
    bit          finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_result_port dut (
        .clk(clk), .rst_n(rst_n), .res_strobe(res_strobe), .res_word(res_word),
        .cs_n(cs_n), .sclk(sclk), .sdo(sdo), .sdo_oe(sdo_oe), .drdy_n(drdy_n));

    function automatic logic bit_of(logic [15:0] w, int i);
        return w[15 - i];
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ticks(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cs(logic v);
        cs_n = v;
        ticks(6);
    endtask

    task automatic set_sclk(logic v);
        sclk = v;
        ticks(6);
    endtask

    task automatic load(logic [15:0] w);
        res_word   = w;
        res_strobe = 1'b1;
        ticks(1);
        res_strobe = 1'b0;
        check("R2 notice cycle 1", drdy_n, 1);
        ticks(1);
        check("R2 notice cycle 2", drdy_n, 1);
        ticks(1);
        check("R2 ready after attempt", drdy_n, 0);
    endtask

    task automatic select_and_arm(logic [15:0] w);
        set_cs(1'b0);
        check("R5 enable on select", sdo_oe, 1);
        check("R5 msb on select", sdo, bit_of(w, 0));
        set_sclk(1'b1);
        check("R6 msb after arming", sdo, bit_of(w, 0));
    endtask

    task automatic shift_to(logic [15:0] w, int k);
        for (int i = 1; i <= k; i++) begin
            set_sclk(1'b0);
            check("R7 shifted bit", sdo, bit_of(w, i));
            check("R7 line enabled", sdo_oe, 1);
            set_sclk(1'b1);
        end
    endtask

    task automatic read_from(logic [15:0] w, int start);
        shift_to(w, 15 - 0);
        set_sclk(1'b0);
        check("R8 released after lsb", sdo_oe, 0);
        check("R8 ready high when empty", drdy_n, 1);
        if (start < 0) $display("unused");
    endtask

    task automatic read_rest(logic [15:0] w, int start);
        for (int i = start + 1; i < 16; i++) begin
            set_sclk(1'b0);
            check("R7 shifted bit", sdo, bit_of(w, i));
            set_sclk(1'b1);
        end
        set_sclk(1'b0);
        check("R8 released after lsb", sdo_oe, 0);
        check("R8 ready high when empty", drdy_n, 1);
    endtask

    task automatic abort_and_restart(logic [15:0] w, int k);
        set_cs(1'b1);
        check("R9 bit held after abort", sdo, bit_of(w, k));
        check("R9 line still driven", sdo_oe, 1);
        set_sclk(1'b0);
        check("R9 released on falling edge", sdo_oe, 0);
        check("R9 port still full", drdy_n, 0);
        set_cs(1'b0);
        check("R10 restart enable", sdo_oe, 1);
        check("R10 restart at msb", sdo, bit_of(w, 0));
        set_sclk(1'b1);
        read_rest(w, 0);
    endtask

    initial begin
        logic [15:0] w, w2;
        int          k;
        int          seed_dummy;
        seed_dummy = $urandom(32'h5EED_0421);
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; res_strobe = 1'b0; res_word = '0;
        ticks(3);
        check("R1 ready high", drdy_n, 1);
        check("R1 line released", sdo_oe, 0);
        check("R1 data low", sdo, 0);
        rst_n = 1'b1;
        ticks(4);

        // plain read
        w = 16'hA5C3;
        load(w);
        select_and_arm(w);
        read_rest(w, 0);
        set_cs(1'b1);

        // R6: clock idles high at selection; first falling edge ignored
        set_sclk(1'b1);
        w = 16'h4B2D;
        load(w);
        set_cs(1'b0);
        check("R5 msb with clock high", sdo, bit_of(w, 0));
        set_sclk(1'b0);
        check("R6 unarmed fall ignored", sdo, bit_of(w, 0));
        check("R6 line still driven", sdo_oe, 1);
        set_sclk(1'b1);
        read_rest(w, 0);
        set_cs(1'b1);

        // R3: overwrite while deselected
        load(16'h1234);
        w = 16'h8E71;
        load(w);
        select_and_arm(w);
        read_rest(w, 0);
        set_cs(1'b1);

        // R4: load discarded during a read
        w  = 16'h6C39;
        w2 = 16'h93C6;
        load(w);
        select_and_arm(w);
        shift_to(w, 5);
        load(w2);
        check("R4 line still driven", sdo_oe, 1);
        check("R4 old bit kept", sdo, bit_of(w, 5));
        read_rest(w, 5);
        check("R4 discarded word absent", sdo_oe, 0);
        set_cs(1'b1);

        // R9 / R10: abort and restart
        w = 16'hD00B;
        load(w);
        select_and_arm(w);
        shift_to(w, 7);
        abort_and_restart(w, 7);
        set_cs(1'b1);

        // R11: load attempt coincides with the completing falling edge
        w  = 16'h3C5A;
        w2 = 16'hB1E7;
        load(w);
        select_and_arm(w);
        shift_to(w, 15);
        sclk = 1'b0; res_word = w2; res_strobe = 1'b1;
        ticks(1);
        res_strobe = 1'b0;
        ticks(7);
        check("R11 ready low after collision", drdy_n, 0);
        check("R11 line driven again", sdo_oe, 1);
        check("R11 new msb", sdo, bit_of(w2, 0));
        set_sclk(1'b1);
        read_rest(w2, 0);
        set_cs(1'b1);

        // constrained random reads, some aborted
        for (int it = 0; it < 8; it++) begin
            w = 16'($urandom);
            k = $urandom_range(14, 1);
            load(w);
            select_and_arm(w);
            shift_to(w, k);
            if (it % 2 == 1) abort_and_restart(w, k);
            else             read_rest(w, k);
            set_cs(1'b1);
        end

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end
endmodule